// File: doc/BRIEF.md
# Two-Stage Reloadable Interval Timer

The block is a down-counting interval timer that runs on the system clock. A narrow prescale counter divides the clock. Each time the prescaler counts down past zero, a wide main counter steps down by one. When the main counter itself counts down past zero, the block flags an interrupt. Each counter refills from its own programmed value, so the interrupt repeats every (period+1) × (divide+1) clocks.

Software uses a simple synchronous port to program the block. One write writes a register. Reads are combinational from the address. The control register does four things: it starts and stops counting, it gates the interrupt pulse, it issues a reload command, and it clears the sticky interrupt flag. The live values of both counters can be read back at any time.

Top module: `interval_timer`

Register addresses: 0 = control, 1 = period, 2 = divide, 3 = main count (read only), 4 = prescale count (read only). Control bits: bit 0 = run, bit 1 = interrupt enable, bit 2 = reload command (write only, reads 0), bit 3 = sticky flag on read and write-one-to-clear on write.

## Requirements
- R1: After reset, the block is in this state:
  - run, enable, flag and `irq` are all 0.
  - The period register holds `PERIOD_RST` and the divide register holds `DIV_RST`.
  - The main count equals `PERIOD_RST` and the prescale count equals `DIV_RST`.
- R2: While running, the prescale count decreases by one each clock. On a clock where it is zero, it refills from the divide register instead.
- R3: The main count decreases by one only on a clock where the prescaler is zero while running. If the main count is zero on that clock, it refills from the period register, and that clock is a borrow.
- R4: With period P and divide D, consecutive borrows are exactly (P+1)×(D+1) clocks apart. The first borrow comes (P+1)×(D+1) clocks after a reload.
- R5: `irq` goes high for one clock after each borrow, and only when the enable bit is 1. When the interval is longer than one clock, `irq` falls again on the next clock.
- R6: The sticky flag (control bit 3) sets on every borrow, whatever the enable bit holds. Writing control with bit 3 = 1 clears it. A borrow on the same clock wins over the clear.
- R7: A control write with bit 2 = 1 copies the period register into the main count and the divide register into the prescale count. Writing the period or divide registers does not change either count.
- R8: While run is 0, both counts hold their values.
- R9: A control read returns run in bit 0, enable in bit 1, 0 in bit 2 and the flag in bit 3. Counter reads return the live counts, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The bench builds the timer with an 8-bit main counter, a 4-bit prescaler, and reset values of 5 and 3. This makes every period/divide pair from 0 to 3 quick to run. The bench sweeps all sixteen pairs. For each pair it measures the clocks from the reload to the first interrupt and to the second, and compares both against (P+1)(D+1). The one-clock case exercises back-to-back interrupts. The small widths also allow single-step reads of both counters, hold checks while stopped, and flag behaviour with the enable both on and off.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1,
  parameter logic [PSC_W-1:0] DIV_RST    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PER  = 3'd1;
  localparam logic [2:0] A_DIV  = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_PSC  = 3'd4;

  logic [CNT_W-1:0] per_q, cnt_q;
  logic [PSC_W-1:0] div_q, psc_q;
  logic run_q, ien_q, flag_q, irq_q;

  wire wr_ctrl = wr_en && (wr_addr == A_CTRL);
  wire reload  = wr_ctrl && wr_data[2];
  wire psc_z   = (psc_q == '0);
  wire cnt_z   = (cnt_q == '0);
  wire step    = run_q && psc_z && !reload;
  wire borrow  = step && cnt_z;

  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= PERIOD_RST;
      div_q  <= DIV_RST;
      cnt_q  <= PERIOD_RST;
      psc_q  <= DIV_RST;
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data[0];
        ien_q <= wr_data[1];
      end
      if (wr_en && wr_addr == A_PER) per_q <= wr_data[CNT_W-1:0];
      if (wr_en && wr_addr == A_DIV) div_q <= wr_data[PSC_W-1:0];

      if (reload) begin
        cnt_q <= per_q;
        psc_q <= div_q;
      end else if (run_q) begin
        psc_q <= psc_z ? div_q : psc_q - 1'b1;
        if (step) cnt_q <= cnt_z ? per_q : cnt_q - 1'b1;
      end

      irq_q <= borrow && ien_q;
      if (borrow) flag_q <= 1'b1;
      else if (wr_ctrl && wr_data[3]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[3:0] = {flag_q, 1'b0, ien_q, run_q};
      A_PER:  rd_data = DATA_W'(per_q);
      A_DIV:  rd_data = DATA_W'(div_q);
      A_CNT:  rd_data = DATA_W'(cnt_q);
      A_PSC:  rd_data = DATA_W'(psc_q);
      default: rd_data = '0;
    endcase
  end

  // R7
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(per_q)) && (psc_q == $past(div_q)));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reload) |=> $stable(cnt_q) && $stable(psc_q));

  // R2
  psc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !reload && psc_q != '0) |=> psc_q == PSC_W'($past(psc_q) - 1'b1));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !reload && psc_q != '0) |=> $stable(cnt_q));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q && $past(ien_q));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !reload && psc_q == '0 && cnt_q == '0) |=> flag_q);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 4;
  localparam int DATA_W = 32;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [DATA_W-1:0] wr_data = 0, rd_data;
  logic irq;
  int checks = 0, errors = 0;

  interval_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W),
    .PERIOD_RST(8'd5), .DIV_RST(4'd3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  function automatic logic [DATA_W-1:0] rd(input logic [2:0] a);
    rd_addr = a;
    return rd_data;
  endfunction

  task automatic rdc(input logic [2:0] a, output logic [DATA_W-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [DATA_W-1:0] v, v2;
    int n;
    int irqs;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    rdc(3'd0, v); chk("R1 ctrl", v, 0);
    rdc(3'd3, v); chk("R1 count", v, 5);
    rdc(3'd4, v); chk("R1 prescale", v, 3);
    rdc(3'd1, v); chk("R1 period", v, 5);
    chk("R1 irq", irq, 0);
    // R8 stopped after reset: counts hold
    cyc(6);
    rdc(3'd3, v); chk("R8 count hold", v, 5);
    rdc(3'd4, v); chk("R8 prescale hold", v, 3);
    // R7 period/divide writes do not move counts
    wr(3'd1, 10); wr(3'd2, 2);
    rdc(3'd3, v); chk("R7 count untouched", v, 5);
    rdc(3'd4, v); chk("R7 prescale untouched", v, 3);
    wr(3'd0, 32'h4);
    rdc(3'd3, v); chk("R7 reload count", v, 10);
    rdc(3'd4, v); chk("R7 reload prescale", v, 2);
    // R9 control encoding
    wr(3'd0, 32'h2);
    rdc(3'd0, v); chk("R9 ctrl readback", v, 2);
    // R2/R3 single steps: run + reload, D=2, P=10
    wr(3'd0, 32'h5);
    rdc(3'd4, v); chk("R7 run reload prescale", v, 2);
    cyc(1);
    rdc(3'd4, v); chk("R2 prescale dec", v, 1);
    rdc(3'd3, v); chk("R3 count held", v, 10);
    cyc(2);
    rdc(3'd4, v); chk("R2 prescale refill", v, 2);
    rdc(3'd3, v); chk("R3 count dec", v, 9);
    // R8 stop holds
    cyc(4); wr(3'd0, 32'h0);
    rdc(3'd3, v); rdc(3'd4, v2);
    cyc(9);
    rdc(3'd3, v); chk("R8 count stable", v, rd(3'd3));
    begin
      logic [DATA_W-1:0] a, b;
      rdc(3'd3, a); cyc(5); rdc(3'd3, b); chk("R8 count stable", b, a);
      rdc(3'd4, a); cyc(5); rdc(3'd4, b); chk("R8 prescale stable", b, a);
    end
    // R6 flag with enable off, no irq (R5)
    wr(3'd1, 1); wr(3'd2, 1); wr(3'd0, 32'h5);
    irqs = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (irq) irqs++; end
    chk("R5 no irq when disabled", irqs, 0);
    wr(3'd0, 32'h0);
    rdc(3'd0, v); chk("R6 flag set disabled", v[3], 1);
    wr(3'd0, 32'h8);
    rdc(3'd0, v); chk("R6 flag cleared", v[3], 0);
    // R4/R5 sweep over all P,D in 0..3
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        wr(3'd1, p); wr(3'd2, d); wr(3'd0, 32'h7);
        n = 0;
        do begin cyc(1); n++; end while (!irq && n < 100);
        chk($sformatf("R4 first P%0d D%0d", p, d), n, (p+1)*(d+1));
        n = 0;
        do begin cyc(1); n++; end while (!irq && n < 100);
        chk($sformatf("R4 repeat P%0d D%0d", p, d), n, (p+1)*(d+1));
        if ((p+1)*(d+1) > 1) begin
          cyc(1);
          chk($sformatf("R5 pulse width P%0d D%0d", p, d), irq, 0);
        end
        wr(3'd0, 32'h0);
        rdc(3'd0, v); chk("R6 flag set enabled", v[3], 1);
        wr(3'd0, 32'h8);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule